// File: doc/BRIEF.md
# Floating-Point Stage Reservation Scoreboard

This block decides, cycle by cycle, whether a floating-point operation may enter a unit made of eight stages, each of which exists only once. Every operation class follows its own fixed schedule: in each cycle after it enters, it occupies some set of stages. A stage may be occupied several times, in cycles that are not adjacent, and together with other stages. The block keeps a record of which stages are already promised to operations in flight for each upcoming cycle. It admits a new operation only if that operation's schedule, started in the current cycle, collides with none of those promises.

A requester presents an operation code with a valid flag. When the schedule fits, `req_ready` is high, the operation is accepted on that clock edge, and its schedule is added to the record. When it does not fit, `stall` is raised. The requester then keeps the same code on the bus, and the check is repeated every cycle against the record as it ages, until the operation is accepted. At most one operation enters per cycle. The block tracks only stage occupancy. Operands, results and register dependencies are handled elsewhere.

Top module: `fpu_resv_scoreboard`

## Requirements
- R1: Operation codes on `req_op` are 0 no-op, 1 add, 2 subtract, 3 multiply, 4 divide, 5 negate, 6 absolute value, 7 compare. A no-op occupies no stage, so a valid no-op is accepted in any cycle.
- R2: Add and subtract occupy, in cycles 0..3 counted from the accept cycle: unpack; shift+add; add+round; round+shift.
- R3: Multiply occupies unpack; exception+mul1; mul1; mul1; mul1; mul2; mul2+add; round. An add requested 4 or 5 cycles after a multiply is accepted is held until 6 cycles after it. Requested 1 to 3 or 6 and more cycles after, it is accepted at once.
- R4: Divide occupies unpack; add; round; then divide in cycles 3..30; divide+add in cycles 31 and 34; divide+round in cycles 32, 33 and 35; add in cycle 36; round in cycle 37. An add requested 29 to 35 cycles after a divide is held until cycle 36. Requested at 28 or 36, it goes at once.
- R5: Negate and absolute value occupy unpack then shift. Compare occupies unpack, add, round.
- R6: `req_ready` is high exactly when the requested schedule overlaps no recorded occupation. `stall` equals `req_valid` and not `req_ready`. A held request is re-evaluated every cycle.
- R7: An accepted operation's schedule is recorded and blocks later requests. Each recorded occupation expires after its cycle has passed.
- R8: An add followed by a multiply, in any order of gaps of one cycle or more, never stalls the multiply.
- R9: A synchronous reset erases every recorded occupation, so the first request after reset is accepted at once, even when a divide was in flight.
- R10: Two adds in a row: the second is held until 3 cycles after the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | An operation is requested this cycle |
| req_op | input | 3 | Operation code of the request |
| req_ready | output | 1 | The requested schedule fits; a valid request is accepted at this edge |
| stall | output | 1 | A valid request is being held back by a stage collision |

## Verification
A multiply followed by an add is tried at every gap from 1 to 7 cycles. This separates the two colliding gaps from the free ones and shows the held add moves at exactly cycle 6. A divide followed by an add is swept across gaps 28 to 36 to find the edges of the late add/round window. Add-then-multiply, add-then-add and divide-then-divide sequences show that the check considers the offsets at which stages collide, not merely which units are busy. A long pseudo-random mix of all eight codes, with held requests kept stable, is compared every cycle against a behavioural timeline. Reset is applied in the middle of a divide, and no-ops are issued while the unit is busy.

// File: rtl/fpu_resv_scoreboard.sv
module fpu_resv_scoreboard #(
  parameter int DEPTH = 38
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [2:0] req_op,
  output logic       req_ready,
  output logic       stall
);
  localparam int STAGES = 8;

  localparam logic [STAGES-1:0] ST_U = STAGES'(1) << 0;
  localparam logic [STAGES-1:0] ST_S = STAGES'(1) << 1;
  localparam logic [STAGES-1:0] ST_A = STAGES'(1) << 2;
  localparam logic [STAGES-1:0] ST_R = STAGES'(1) << 3;
  localparam logic [STAGES-1:0] ST_M = STAGES'(1) << 4;
  localparam logic [STAGES-1:0] ST_N = STAGES'(1) << 5;
  localparam logic [STAGES-1:0] ST_E = STAGES'(1) << 6;
  localparam logic [STAGES-1:0] ST_D = STAGES'(1) << 7;

  localparam logic [2:0] OP_ADD = 3'd1;
  localparam logic [2:0] OP_SUB = 3'd2;
  localparam logic [2:0] OP_MUL = 3'd3;
  localparam logic [2:0] OP_DIV = 3'd4;
  localparam logic [2:0] OP_NEG = 3'd5;
  localparam logic [2:0] OP_ABS = 3'd6;
  localparam logic [2:0] OP_CMP = 3'd7;

  function automatic logic [STAGES-1:0] usage(input logic [2:0] op, input int k);
    logic [STAGES-1:0] m;
    m = '0;
    case (op)
      OP_ADD, OP_SUB: begin
        if (k == 0)      m = ST_U;
        else if (k == 1) m = ST_S | ST_A;
        else if (k == 2) m = ST_A | ST_R;
        else if (k == 3) m = ST_R | ST_S;
      end
      OP_MUL: begin
        if (k == 0)                m = ST_U;
        else if (k == 1)           m = ST_E | ST_M;
        else if (k >= 2 && k <= 4) m = ST_M;
        else if (k == 5)           m = ST_N;
        else if (k == 6)           m = ST_N | ST_A;
        else if (k == 7)           m = ST_R;
      end
      OP_DIV: begin
        if (k == 0)                  m = ST_U;
        else if (k == 1 || k == 36)  m = ST_A;
        else if (k == 2 || k == 37)  m = ST_R;
        else if (k >= 3 && k <= 30)  m = ST_D;
        else if (k == 31 || k == 34) m = ST_D | ST_A;
        else if (k >= 32 && k <= 35) m = ST_D | ST_R;
      end
      OP_NEG, OP_ABS: begin
        if (k == 0)      m = ST_U;
        else if (k == 1) m = ST_S;
      end
      OP_CMP: begin
        if (k == 0)      m = ST_U;
        else if (k == 1) m = ST_A;
        else if (k == 2) m = ST_R;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  logic [STAGES-1:0] win_q [DEPTH];
  logic [DEPTH-1:0]  hit;
  logic              grant;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign hit[k] = |(win_q[k] & usage(req_op, k));
  end

  assign req_ready = ~|hit;
  assign stall     = req_valid & ~req_ready;
  assign grant     = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) win_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH - 1; k++)
        win_q[k] <= win_q[k+1] | (grant ? usage(req_op, k + 1) : '0);
      win_q[DEPTH-1] <= '0;
    end
  end
endmodule

module fpu_resv_scoreboard_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       req_ready,
  input logic       stall
);
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  logic acc, is_add;
  assign acc    = req_valid && req_ready;
  assign is_add = (req_op == 3'd1) || (req_op == 3'd2);

  a_r9_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> req_ready);

  a_r1_noop_never_held: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd0) |-> !stall);

  a_r3_add_gap4_held: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd5 && $past(acc && req_op == 3'd3, 4) && req_valid && is_add) |-> stall);

  a_r3_add_gap5_held: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd6 && $past(acc && req_op == 3'd3, 5) && req_valid && is_add) |-> stall);

  a_r10_add_gap1_held: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd2 && $past(acc && is_add, 1) && req_valid && is_add) |-> stall);

  a_r10_add_gap2_held: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd3 && $past(acc && is_add, 2) && req_valid && is_add) |-> stall);

  a_r4_div_div_held: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd2 && $past(acc && req_op == 3'd4, 1) && req_valid && req_op == 3'd4) |-> stall);
endmodule

bind fpu_resv_scoreboard fpu_resv_scoreboard_chk chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .req_ready(req_ready), .stall(stall)
);

// File: tb/fpu_resv_scoreboard_tb_top.sv
module fpu_resv_scoreboard_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic       req_ready, stall;

  always #10 clk = ~clk;

  fpu_resv_scoreboard dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_ready(req_ready), .stall(stall)
  );

  int vectors = 0;
  int errors  = 0;

  // behavioural timeline: occupied stage bits per absolute cycle, ring of 64
  int pat [8][$];
  int busy [64];
  int now = 0;

  task automatic clear_model();
    for (int i = 0; i < 64; i++) busy[i] = 0;
  endtask

  function automatic bit fits(input int op);
    foreach (pat[op][k]) if ((busy[(now + k) % 64] & pat[op][k]) != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic claim(input int op);
    foreach (pat[op][k]) busy[(now + k) % 64] |= pat[op][k];
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, now);
    end
  endtask

  task automatic cycle(input bit v, input int op, output bit granted);
    bit e;
    @(negedge clk);
    rst = 1'b0; req_valid = v; req_op = 3'(op);
    #1;
    e = fits(op);
    chk(req_ready == e, "R6 ready", int'(req_ready), int'(e));
    chk(stall == (v && !e), "R6 stall", int'(stall), int'(v && !e));
    granted = v && e;
    @(posedge clk);
    if (granted) claim(op);
    busy[now % 64] = 0;
    now++;
  endtask

  task automatic idle(input int n);
    bit g;
    for (int i = 0; i < n; i++) cycle(1'b0, 0, g);
  endtask

  task automatic hold_issue(input int op, output int waited);
    bit g;
    waited = 0;
    cycle(1'b1, op, g);
    while (!g && waited < 200) begin
      waited++;
      cycle(1'b1, op, g);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0; req_op = 3'd0;
    @(posedge clk);
    @(posedge clk);
    clear_model();
  endtask

  task automatic seq(input int op, input int m0, input int m1, input int m2, input int m3);
    pat[op].push_back(m0);
    if (m1 >= 0) pat[op].push_back(m1);
    if (m2 >= 0) pat[op].push_back(m2);
    if (m3 >= 0) pat[op].push_back(m3);
  endtask

  localparam int U = 1, S = 2, A = 4, R = 8, M = 16, N = 32, E = 64, D = 128;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int w, x;
    bit g;
    logic [15:0] lfsr;
    int hold_op;
    bit holding;

    // R2 R3 R4 R5 schedules
    seq(1, U, S|A, A|R, R|S);
    seq(2, U, S|A, A|R, R|S);
    seq(3, U, E|M, M, M); seq(3, M, N, N|A, R);
    seq(4, U, A, R, -1);
    for (int i = 3; i <= 30; i++) pat[4].push_back(D);
    seq(4, D|A, D|R, D|R, D|A); seq(4, D|R, A, R, -1);
    seq(5, U, S, -1, -1);
    seq(6, U, S, -1, -1);
    seq(7, U, A, R, -1);
    clear_model();

    do_reset();
    @(negedge clk); rst = 1'b0; #1;
    chk(req_ready == 1'b1, "R9 ready after reset", int'(req_ready), 1);
    chk(stall == 1'b0, "R9 no stall after reset", int'(stall), 0);
    @(posedge clk); now++;

    // R3: multiply then add at gaps 1..7
    for (int d = 1; d <= 7; d++) begin
      hold_issue(3, w);
      idle(d - 1);
      hold_issue((d % 2) ? 1 : 2, w);
      x = (d == 4) ? 2 : (d == 5) ? 1 : 0;
      chk(w == x, "R3 add wait after multiply", w, x);
      idle(40);
    end

    // R8: add then multiply
    for (int d = 1; d <= 4; d++) begin
      hold_issue(1, w);
      idle(d - 1);
      hold_issue(3, w);
      chk(w == 0, "R8 multiply after add", w, 0);
      idle(20);
    end

    // R10: back-to-back adds
    hold_issue(1, w);
    hold_issue(2, w);
    chk(w == 2, "R10 second add wait", w, 2);
    idle(20);

    // R4: divide then add, gaps 28..36
    for (int d = 28; d <= 36; d++) begin
      hold_issue(4, w);
      idle(d - 1);
      hold_issue(1, w);
      x = (d >= 29 && d <= 35) ? 36 - d : 0;
      chk(w == x, "R4 add wait after divide", w, x);
      idle(50);
    end

    // R7: divide then divide is held
    hold_issue(4, w);
    hold_issue(4, w);
    chk(w > 0, "R7 divide blocks divide", w, 1);
    idle(80);

    // R1: no-op accepted while divide in flight
    hold_issue(4, w);
    idle(4);
    cycle(1'b1, 0, g);
    chk(g == 1'b1, "R1 no-op accepted", int'(g), 1);
    // R5: negate and compare accepted during divide's quiet stretch
    hold_issue(5, w);
    chk(w == 0, "R5 negate during divide", w, 0);
    hold_issue(7, w);
    idle(60);

    // R9: reset in the middle of a divide
    hold_issue(4, w);
    idle(5);
    do_reset();
    hold_issue(4, w);
    chk(w == 0, "R9 divide right after reset", w, 0);
    idle(50);

    // R6 R7: pseudo-random mix, held requests stay stable
    lfsr = 16'hACE1;
    holding = 1'b0;
    hold_op = 0;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (!holding) begin
        hold_op = int'(lfsr[2:0]);
        if (hold_op == 4 && lfsr[9:8] != 2'b00) hold_op = 5;
        holding = lfsr[5] | lfsr[6];
      end
      cycle(holding, hold_op, g);
      if (g) holding = 1'b0;
    end

    req_valid = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule